// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned operands of `WIDTH` bits with a single full adder, working through one bit pair per clock. Two right-shifting operand registers feed the adder from their least significant ends. A one-bit carry register closes the loop between one bit position and the next. Each sum bit is pushed into the top of the first operand register as that register shifts, so the result takes the place of the first operand and no separate result register is needed.

A mode input picks the phase. With the mode at 0, both registers load the operand inputs in parallel and the carry is cleared. With the mode at 1, the adder runs. A bit counter stops the shifting after exactly `WIDTH` add clocks and raises a done flag. The sum is then held on the result output, with the final carry beside it, until the next load. Everything runs on one clock, and the mode input acts as a load and shift enable rather than as a clock selector.

Top module: `serial_shift_adder`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets sum_out, carry_out and done to 0.
- R2: A rising edge with mode_add at 0 loads opa_in into the first register, so sum_out equals opa_in after that edge, and clears done.
- R3: Starting from a load, done stays 0 for the first WIDTH-1 clocks with mode_add at 1 and becomes 1 after the WIDTH-th such clock.
- R4: When done is 1, {carry_out, sum_out} equals opa_in + opb_in of the last load, with carry_out as bit WIDTH of the sum.
- R5: While done is 1 and mode_add stays 1, sum_out, carry_out and done keep their values.
- R6: Each add clock before done shifts the first register right by one and inserts the new sum bit at bit WIDTH-1. After k add clocks, sum_out equals ((a+b) mod 2^k) shifted left by WIDTH-k, ORed with a shifted right by k.
- R7: A load clears carry_out to 0 even when the previous addition ended with a carry of 1.
- R8: Taking mode_add back to 0 part-way through an addition discards it. The next run takes its operands from the new load and again needs WIDTH add clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_add | input | 1 | 0 = parallel load and carry clear, 1 = shift and add |
| opa_in | input | WIDTH | First operand, captured on load |
| opb_in | input | WIDTH | Second operand, captured on load |
| sum_out | output | WIDTH | First operand register: the partial result during the run, the sum once done |
| carry_out | output | 1 | Carry register; after the run it holds bit WIDTH of the sum |
| done | output | 1 | High once WIDTH add clocks have completed since the last load |

## Verification
The bench builds the adder with WIDTH = 4. At that width every one of the 256 operand pairs can be run in full, and the register contents are checked after each single add clock as well as at the end. This covers every carry chain, including a carry that ripples across all four positions and ends in a final carry of 1. It also covers each load that follows such a result. Separate runs interrupt an addition half-way with a reload and hold the mode at 1 after done to confirm the frozen state.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  // One-bit full adder: returns {carry, sum}.
  function automatic logic [1:0] fa_bit(input logic a, input logic b, input logic cin);
    logic s;
    logic c;
    s = a ^ b ^ cin;
    c = (a & b) | (a & cin) | (b & cin);
    return {c, s};
  endfunction

endpackage

// File: rtl/ssa_operand_reg.sv
module ssa_operand_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= par_in;
    else if (shift) q <= {ser_in, q[W-1:1]};
  end

  AST_SHIFT_INSERTS_TOP: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> (q[W-1] == $past(ser_in)));  // R6

endmodule

// File: rtl/ssa_bit_counter.sv
module ssa_bit_counter #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic done
);

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;
  logic          last_step;

  assign last_step = step && !done && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (step && !done) begin
      cnt <= cnt + 1'b1;
      if (last_step) done <= 1'b1;
    end
  end

  AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(last_step));  // R3

  AST_CLEAR_DROPS_DONE: assert property (@(posedge clk) disable iff (rst)
    clear |=> !done);  // R2

endmodule

// File: rtl/serial_shift_adder.sv
module serial_shift_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_add,
  input  logic [WIDTH-1:0] opa_in,
  input  logic [WIDTH-1:0] opb_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out,
  output logic             done
);

  import ssa_pkg::*;

  logic             load_en;
  logic             shift_en;
  logic [WIDTH-1:0] b_q;
  logic [1:0]       fa_out;
  logic             sum_bit;
  logic             carry_nxt;
  logic             carry_q;

  assign load_en  = !mode_add;
  assign shift_en = mode_add && !done;

  assign fa_out    = fa_bit(sum_out[0], b_q[0], carry_q);
  assign sum_bit   = fa_out[0];
  assign carry_nxt = fa_out[1];

  ssa_operand_reg #(.W(WIDTH)) u_reg_a (
    .clk(clk), .rst(rst), .load(load_en), .shift(shift_en),
    .ser_in(sum_bit), .par_in(opa_in), .q(sum_out)
  );

  ssa_operand_reg #(.W(WIDTH)) u_reg_b (
    .clk(clk), .rst(rst), .load(load_en), .shift(shift_en),
    .ser_in(1'b0), .par_in(opb_in), .q(b_q)
  );

  always_ff @(posedge clk) begin
    if (rst || load_en) carry_q <= 1'b0;
    else if (shift_en)  carry_q <= carry_nxt;
  end

  assign carry_out = carry_q;

  ssa_bit_counter #(.N(WIDTH)) u_count (
    .clk(clk), .rst(rst), .clear(load_en), .step(shift_en), .done(done)
  );

  AST_LOAD_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
    !mode_add |=> (carry_out == 1'b0));  // R7

  AST_LOAD_TAKES_A: assert property (@(posedge clk) disable iff (rst)
    !mode_add |=> (sum_out == $past(opa_in)));  // R2

  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (sum_out[WIDTH-2:0] == $past(sum_out[WIDTH-1:1])));  // R6

  AST_HOLD_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    (mode_add && done) |=> (done && $stable(sum_out) && $stable(carry_out)));  // R5

endmodule

// File: tb/serial_shift_adder_tb.sv
`timescale 1ns/1ps
module serial_shift_adder_tb;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_add = 1'b0;
  logic [N-1:0] opa_in = '0;
  logic [N-1:0] opb_in = '0;
  logic [N-1:0] sum_out;
  logic         carry_out;
  logic         done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_shift_adder #(.WIDTH(N)) u_dut (
    .clk(clk), .rst(rst), .mode_add(mode_add),
    .opa_in(opa_in), .opb_in(opb_in),
    .sum_out(sum_out), .carry_out(carry_out), .done(done)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(input int a, input int b);
    mode_add = 1'b0;
    opa_in = N'(a);
    opb_in = N'(b);
    tick();
    check("R2 load sum_out", int'(sum_out), a);
    check("R7 load carry", int'(carry_out), 0);
    check("R2 load done", int'(done), 0);
  endtask

  function automatic int partial(input int a, input int b, input int k);
    int s;
    int lo;
    s = a + b;
    lo = s % (1 << k);
    return ((lo << (N - k)) | (a >> k)) & ((1 << N) - 1);
  endfunction

  task automatic run_add(input int a, input int b);
    mode_add = 1'b1;
    for (int k = 1; k <= N; k++) begin
      tick();
      check("R6 partial", int'(sum_out), partial(a, b, k));
      if (k < N) check("R3 done low", int'(done), 0);
      else       check("R3 done high", int'(done), 1);
    end
    check("R4 result", int'({carry_out, sum_out}), a + b);
  endtask

  initial begin
    repeat (2) tick();
    check("R1 reset sum", int'(sum_out), 0);
    check("R1 reset carry", int'(carry_out), 0);
    check("R1 reset done", int'(done), 0);
    rst = 1'b0;

    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        do_load(a, b);
        run_add(a, b);
      end
    end

    // R5: hold after done
    do_load(15, 9);
    run_add(15, 9);
    repeat (3) begin
      tick();
      check("R5 hold sum", int'(sum_out), (15 + 9) % 16);
      check("R5 hold carry", int'(carry_out), 1);
      check("R5 hold done", int'(done), 1);
    end

    // R7: load after carry-out of 1
    do_load(3, 4);
    check("R7 carry cleared", int'(carry_out), 0);
    run_add(3, 4);

    // R8: abort half-way, reload, full run again
    do_load(7, 7);
    mode_add = 1'b1;
    tick();
    tick();
    check("R8 mid-run not done", int'(done), 0);
    do_load(5, 12);
    run_add(5, 12);

    // R1: reset after a finished run
    rst = 1'b1;
    tick();
    check("R1 reset sum again", int'(sum_out), 0);
    check("R1 reset carry again", int'(carry_out), 0);
    check("R1 reset done again", int'(done), 0);
    rst = 1'b0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule